// File: doc/BRIEF.md
# Hierarchical Interrupt Status Bank

This block collects interrupt events for a device with twelve transmit queues. The per-queue bits do not fit in a single word. Queue events and a few miscellaneous events are therefore latched into four secondary status words. A primary status word holds events that are latched directly, together with summary bits. Each summary bit is the OR of a group of secondary bits. A level interrupt output is raised whenever a primary bit is set and enabled in a mask word.

Software reaches the bank through a small word-addressed port. Reads are combinational in the cycle that `bus_rd` is high, and the write data is taken at the clock edge. Software can acknowledge events in two ways. The first is a write-one-to-clear on any live status word. The second is a read of an atomic read-and-clear alias. That read returns the primary value, copies all four secondary words into shadow words, and clears the live words. Any event that arrives in the same cycle as either kind of clear stays set, so no interrupt is lost.

Address map (word index): 0 primary, 1 to 4 secondary 0 to 3, 5 read-and-clear alias, 6 to 9 shadow 0 to 3, 10 enable mask. All other addresses read zero.

Top module: `isr_bank`

## Requirements
- R1: After reset, every status word, shadow word and the mask read zero, and `irq` is low.
- R2: Event pulses latch into the secondary words at these positions (queue q, 0 to 11). Word 0 holds done at bit q and descriptor at bit 16+q. Word 1 holds error at bit q and end-of-list at bit 16+q. Word 2 holds underrun at bit q, host errors at bits 12, 13 and 14, and six beacon events at bits 16 to 21. Word 3 holds CBR overrun at bit c, CBR underrun at bit 10+c and schedule trigger at bit 20+c (c from 0 to 9). All other bits read 0.
- R3: `ev_direct` bits latch straight into the primary word, the transmit-timeout bit 9 among them. `ev_direct` bits at summary positions are ignored.
- R4: Each primary summary bit is the OR of one group. Bit 6 takes the done bits, 7 the descriptor bits, 8 the error bits, 10 the end-of-list bits and 11 the underrun bits. Bit 19 takes the host error bits and bit 23 the beacon bits. Bits 25, 26 and 27 take CBR overrun, CBR underrun and trigger.
- R5: A write to a live secondary word clears exactly the bits written as 1.
- R6: A write to the primary word clears only the directly latched bits written as 1. A summary bit falls only when all of its group is clear.
- R7: An event that arrives in the same cycle as a write-one-to-clear of its bit leaves the bit set.
- R8: A read of the alias returns the primary value, copies each secondary word into its shadow and clears all live words.
- R9: An event that arrives in the cycle of an alias read is set in the live word afterwards, and it does not appear in the shadow.
- R10: The mask word can be read and written. `irq` is high exactly when the primary word AND the mask is non-zero.
- R11: Writes to the alias, the shadows and unmapped addresses change nothing. Unmapped addresses, and any address while `bus_rd` is low, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Word address |
| bus_rd | input | 1 | Read strobe; data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| ev_txok | input | 12 | Per-queue transmit done |
| ev_txdesc | input | 12 | Per-queue descriptor request |
| ev_txerr | input | 12 | Per-queue transmit error |
| ev_txeol | input | 12 | Per-queue end of descriptor list |
| ev_txurn | input | 12 | Per-queue FIFO underrun |
| ev_hif | input | 3 | Host error: master abort, system error, parity |
| ev_bcn | input | 6 | Beacon-related miscellaneous events |
| ev_cbr_ovr | input | 10 | Per-queue CBR overrun |
| ev_cbr_urn | input | 10 | Per-queue CBR underrun |
| ev_qtrig | input | 10 | Per-queue scheduling trigger |
| ev_direct | input | 32 | Events latched directly in the primary word |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the cycle where a clear and a new event meet. If the clear were given priority, a write-one-to-clear or an alias read would silently drop the event that arrived with it. It also writes all ones to the primary word while secondary bits are pending. A design that stored summary bits as flops would lose them there even though the queue bits are still set. Alias reads are checked through the shadows and the live words. Mixing up the order of snapshot and clear would either leave the shadows empty or let a same-cycle event leak into the shadows.

// File: rtl/isr_pkg.sv
// Package: address map, primary bit positions and secondary field layout
// shared by the interrupt status bank and its checker.
// Assumes at most 12 transmit queues and at most 10 CBR queues.
package isr_pkg;
    localparam int AW = 4;
    localparam int DW = 32;

    typedef enum logic [AW-1:0] {
        A_PRI  = 4'd0,
        A_SEC0 = 4'd1,
        A_SEC1 = 4'd2,
        A_SEC2 = 4'd3,
        A_SEC3 = 4'd4,
        A_RAC  = 4'd5,
        A_SHD0 = 4'd6,
        A_SHD1 = 4'd7,
        A_SHD2 = 4'd8,
        A_SHD3 = 4'd9,
        A_MASK = 4'd10
    } isr_addr_e;

    // primary positions (decoded by software, so kept fixed)
    localparam int P_TXOK   = 6;
    localparam int P_TXDESC = 7;
    localparam int P_TXERR  = 8;
    localparam int P_TXEOL  = 10;
    localparam int P_TXURN  = 11;
    localparam int P_HIF    = 19;
    localparam int P_BCN    = 23;
    localparam int P_CBRO   = 25;
    localparam int P_CBRU   = 26;
    localparam int P_QTRIG  = 27;

    localparam logic [DW-1:0] SUM_MASK =
        (DW'(1) << P_TXOK) | (DW'(1) << P_TXDESC) | (DW'(1) << P_TXERR) |
        (DW'(1) << P_TXEOL) | (DW'(1) << P_TXURN) | (DW'(1) << P_HIF) |
        (DW'(1) << P_BCN) | (DW'(1) << P_CBRO) | (DW'(1) << P_CBRU) |
        (DW'(1) << P_QTRIG);

    // secondary field layout
    localparam int HI_OFS    = 16;  // upper queue field in words 0 and 1
    localparam int HIF_OFS   = 12;  // host errors in word 2
    localparam int HIF_W     = 3;
    localparam int BCN_OFS   = 16;  // beacon events in word 2
    localparam int BCN_W     = 6;
    localparam int CBRO_OFS  = 0;   // word 3 fields
    localparam int CBRU_OFS  = 10;
    localparam int QTRIG_OFS = 20;
    localparam int NSEC      = 4;
endpackage

// File: rtl/isr_evt_map.sv
// Module: routes the raw event pulses onto the set vectors of the four
// secondary words. Purely combinational; assumes NQ <= 12 and NCBR <= 10.
module isr_evt_map
    import isr_pkg::*;
#(
    parameter int NQ   = 12,
    parameter int NCBR = 10
) (
    input  logic [NQ-1:0]             ev_txok,
    input  logic [NQ-1:0]             ev_txdesc,
    input  logic [NQ-1:0]             ev_txerr,
    input  logic [NQ-1:0]             ev_txeol,
    input  logic [NQ-1:0]             ev_txurn,
    input  logic [HIF_W-1:0]          ev_hif,
    input  logic [BCN_W-1:0]          ev_bcn,
    input  logic [NCBR-1:0]           ev_cbr_ovr,
    input  logic [NCBR-1:0]           ev_cbr_urn,
    input  logic [NCBR-1:0]           ev_qtrig,
    output logic [NSEC-1:0][DW-1:0]   sec_set
);
    // place each event group at its field (R2)
    always_comb begin
        sec_set = '0;
        sec_set[0][0 +: NQ]         = ev_txok;
        sec_set[0][HI_OFS +: NQ]    = ev_txdesc;
        sec_set[1][0 +: NQ]         = ev_txerr;
        sec_set[1][HI_OFS +: NQ]    = ev_txeol;
        sec_set[2][0 +: NQ]         = ev_txurn;
        sec_set[2][HIF_OFS +: HIF_W] = ev_hif;
        sec_set[2][BCN_OFS +: BCN_W] = ev_bcn;
        sec_set[3][CBRO_OFS +: NCBR]  = ev_cbr_ovr;
        sec_set[3][CBRU_OFS +: NCBR]  = ev_cbr_urn;
        sec_set[3][QTRIG_OFS +: NCBR] = ev_qtrig;
    end
endmodule

// File: rtl/isr_wc_reg.sv
// Module: one status word with set-dominant clear. Bits outside VALID are
// held at zero. Assumes clr is already gated by address decode.
module isr_wc_reg #(
    parameter int              W     = 32,
    parameter logic [W-1:0]    VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // clear first, then set, so a new event always survives (R7, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr) | set) & VALID;
    end
endmodule

// File: rtl/isr_summary.sv
// Module: forms the primary summary bits as ORs of secondary groups.
// Combinational; the summary is never stored, so it cannot be cleared
// apart from its contributors.
module isr_summary
    import isr_pkg::*;
#(
    parameter int NQ   = 12,
    parameter int NCBR = 10
) (
    input  logic [NSEC-1:0][DW-1:0] sec_q,
    output logic [DW-1:0]           sum
);
    // one OR reduction per summary bit (R4)
    always_comb begin
        sum = '0;
        sum[P_TXOK]   = |sec_q[0][0 +: NQ];
        sum[P_TXDESC] = |sec_q[0][HI_OFS +: NQ];
        sum[P_TXERR]  = |sec_q[1][0 +: NQ];
        sum[P_TXEOL]  = |sec_q[1][HI_OFS +: NQ];
        sum[P_TXURN]  = |sec_q[2][0 +: NQ];
        sum[P_HIF]    = |sec_q[2][HIF_OFS +: HIF_W];
        sum[P_BCN]    = |sec_q[2][BCN_OFS +: BCN_W];
        sum[P_CBRO]   = |sec_q[3][CBRO_OFS +: NCBR];
        sum[P_CBRU]   = |sec_q[3][CBRU_OFS +: NCBR];
        sum[P_QTRIG]  = |sec_q[3][QTRIG_OFS +: NCBR];
    end
endmodule

// File: rtl/isr_bank.sv
// Module: hierarchical interrupt status bank. Holds four secondary words,
// the direct part of the primary word, four shadows and an enable mask.
// Decodes a word-addressed port with a combinational read. Assumes at
// most one of bus_rd and bus_wr is high in a cycle.
module isr_bank
    import isr_pkg::*;
#(
    parameter int NQ   = 12,
    parameter int NCBR = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NQ-1:0]     ev_txok,
    input  logic [NQ-1:0]     ev_txdesc,
    input  logic [NQ-1:0]     ev_txerr,
    input  logic [NQ-1:0]     ev_txeol,
    input  logic [NQ-1:0]     ev_txurn,
    input  logic [HIF_W-1:0]  ev_hif,
    input  logic [BCN_W-1:0]  ev_bcn,
    input  logic [NCBR-1:0]   ev_cbr_ovr,
    input  logic [NCBR-1:0]   ev_cbr_urn,
    input  logic [NCBR-1:0]   ev_qtrig,
    input  logic [DW-1:0]     ev_direct,
    output logic              irq
);
    localparam logic [DW-1:0] QMASK = DW'((64'd1 << NQ) - 64'd1);
    localparam logic [DW-1:0] CMASK = DW'((64'd1 << NCBR) - 64'd1);
    localparam logic [DW-1:0] DIR_VALID = ~SUM_MASK;

    // valid bits of each secondary word
    function automatic logic [DW-1:0] sec_valid(input int idx);
        case (idx)
            0, 1:    return QMASK | (QMASK << HI_OFS);
            2:       return QMASK | (DW'((1 << HIF_W) - 1) << HIF_OFS) |
                            (DW'((1 << BCN_W) - 1) << BCN_OFS);
            default: return (CMASK << CBRO_OFS) | (CMASK << CBRU_OFS) |
                            (CMASK << QTRIG_OFS);
        endcase
    endfunction

    logic [NSEC-1:0][DW-1:0] sec_set;
    logic [NSEC-1:0][DW-1:0] sec_q;
    logic [NSEC-1:0][DW-1:0] shd_q;
    logic [DW-1:0]           dir_q;
    logic [DW-1:0]           sum;
    logic [DW-1:0]           pri;
    logic [DW-1:0]           mask_q;
    logic                    rac;
    logic [DW-1:0]           dir_clr;

    isr_evt_map #(.NQ(NQ), .NCBR(NCBR)) u_map (
        .ev_txok(ev_txok), .ev_txdesc(ev_txdesc), .ev_txerr(ev_txerr),
        .ev_txeol(ev_txeol), .ev_txurn(ev_txurn), .ev_hif(ev_hif),
        .ev_bcn(ev_bcn), .ev_cbr_ovr(ev_cbr_ovr), .ev_cbr_urn(ev_cbr_urn),
        .ev_qtrig(ev_qtrig), .sec_set(sec_set)
    );

    // alias read is the only read with a side effect (R8)
    assign rac = bus_rd && (bus_addr == A_RAC);

    // one live secondary word per index, cleared by its write or the alias
    for (genvar i = 0; i < NSEC; i++) begin : g_sec
        localparam logic [AW-1:0] MY_ADDR = AW'(int'(A_SEC0) + i);
        logic [DW-1:0] clr;

        // clear source for this word (R5, R8)
        always_comb begin
            if (rac)                                clr = '1;
            else if (bus_wr && bus_addr == MY_ADDR) clr = bus_wdata;
            else                                    clr = '0;
        end

        isr_wc_reg #(.W(DW), .VALID(sec_valid(i))) u_reg (
            .clk(clk), .rst_n(rst_n), .set(sec_set[i]), .clr(clr), .q(sec_q[i])
        );
    end

    // clear source for the direct primary bits (R6, R8)
    always_comb begin
        if (rac)                              dir_clr = '1;
        else if (bus_wr && bus_addr == A_PRI) dir_clr = bus_wdata;
        else                                  dir_clr = '0;
    end

    isr_wc_reg #(.W(DW), .VALID(DIR_VALID)) u_dir (
        .clk(clk), .rst_n(rst_n), .set(ev_direct), .clr(dir_clr), .q(dir_q)
    );

    isr_summary #(.NQ(NQ), .NCBR(NCBR)) u_sum (.sec_q(sec_q), .sum(sum));

    assign pri = dir_q | sum;

    // snapshot pre-clear secondaries on an alias read (R8, R9)
    always_ff @(posedge clk) begin
        if (!rst_n)   shd_q <= '0;
        else if (rac) shd_q <= sec_q;
    end

    // enable mask register (R10)
    always_ff @(posedge clk) begin
        if (!rst_n)                            mask_q <= '0;
        else if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata;
    end

    // level interrupt from enabled primary bits (R10)
    assign irq = |(pri & mask_q);

    // read multiplexer; zero when idle or unmapped (R11)
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_PRI, A_RAC: bus_rdata = pri;
                A_SEC0:       bus_rdata = sec_q[0];
                A_SEC1:       bus_rdata = sec_q[1];
                A_SEC2:       bus_rdata = sec_q[2];
                A_SEC3:       bus_rdata = sec_q[3];
                A_SHD0:       bus_rdata = shd_q[0];
                A_SHD1:       bus_rdata = shd_q[1];
                A_SHD2:       bus_rdata = shd_q[2];
                A_SHD3:       bus_rdata = shd_q[3];
                A_MASK:       bus_rdata = mask_q;
                default:      bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/isr_bank_chk.sv
// Module: assertion checker for isr_bank, bound to every instance.
// Assumes bus_rd and bus_wr are never high together.
module isr_bank_chk
    import isr_pkg::*;
#(
    parameter int NQ = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rac,
    input logic [NSEC*DW-1:0]    sec_set_f,
    input logic [NSEC*DW-1:0]    sec_q_f,
    input logic [NSEC*DW-1:0]    shd_f,
    input logic [DW-1:0]         pri,
    input logic [DW-1:0]         mask,
    input logic                  irq
);
    // R1: state is zero in the first cycle after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sec_q_f == '0 && shd_f == '0 && mask == '0 && !irq));

    // R7: a set bit is always present in the next cycle, whatever the clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sec_q_f & $past(sec_set_f)) == $past(sec_set_f)));

    // R8: shadows hold the pre-clear secondaries after an alias read
    a_r8_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n)
        rac |=> (shd_f == $past(sec_q_f)));

    // R9: after an alias read only the same-cycle events remain live
    a_r9_keep_new: assert property (@(posedge clk) disable iff (!rst_n)
        rac |=> (sec_q_f == $past(sec_set_f)));

    // R4: a pending done bit forces its primary summary
    a_r4_txok_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (|sec_q_f[NQ-1:0]) |-> pri[P_TXOK]);

    // R10: no enabled bits, no interrupt
    a_r10_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

bind isr_bank isr_bank_chk #(.NQ(NQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .rac(rac), .sec_set_f(sec_set),
    .sec_q_f(sec_q), .shd_f(shd_q), .pri(pri), .mask(mask_q), .irq(irq)
);

// File: tb/tb_isr_bank.sv
`timescale 1ns/1ps
module tb_isr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [11:0] g_txok = '0, g_txdesc = '0, g_txerr = '0, g_txeol = '0, g_txurn = '0;
    logic [2:0]  g_hif = '0;
    logic [5:0]  g_bcn = '0;
    logic [9:0]  g_ovr = '0, g_urn = '0, g_trig = '0;
    logic [31:0] g_dir = '0;

    int checks = 0;
    int errors = 0;

    // bench model of the bank state
    logic [31:0] m_sec [4];
    logic [31:0] m_shd [4];
    logic [31:0] m_dir, m_mask;

    always #10 clk = ~clk;

    isr_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_txok(g_txok), .ev_txdesc(g_txdesc), .ev_txerr(g_txerr),
        .ev_txeol(g_txeol), .ev_txurn(g_txurn), .ev_hif(g_hif), .ev_bcn(g_bcn),
        .ev_cbr_ovr(g_ovr), .ev_cbr_urn(g_urn), .ev_qtrig(g_trig),
        .ev_direct(g_dir), .irq(irq)
    );

    localparam logic [31:0] SUMBITS = 32'h0E88_0DC0;

    // valid bits per secondary word, from R2
    function automatic logic [31:0] vmask(input int i);
        case (i)
            0, 1:    return 32'h0FFF_0FFF;
            2:       return 32'h003F_7FFF;
            default: return 32'h3FFF_FFFF;
        endcase
    endfunction

    // primary value from R3/R4
    function automatic logic [31:0] m_pri();
        logic [31:0] p;
        p = m_dir;
        p[6]  = |m_sec[0][11:0];
        p[7]  = |m_sec[0][27:16];
        p[8]  = |m_sec[1][11:0];
        p[10] = |m_sec[1][27:16];
        p[11] = |m_sec[2][11:0];
        p[19] = |m_sec[2][14:12];
        p[23] = |m_sec[2][21:16];
        p[25] = |m_sec[3][9:0];
        p[26] = |m_sec[3][19:10];
        p[27] = |m_sec[3][29:20];
        return p;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0, 4'd5: return m_pri();
            4'd1, 4'd2, 4'd3, 4'd4: return m_sec[a - 4'd1];
            4'd6, 4'd7, 4'd8, 4'd9: return m_shd[a - 4'd6];
            4'd10: return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R4";
            4'd1, 4'd2, 4'd3, 4'd4: return "R5";
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R8";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive, check read data and irq, update model
    task automatic step(input logic [3:0] a, input logic rd, input logic wr,
                        input logic [31:0] wd, input string tag);
        logic [31:0] set [4];
        logic [31:0] clr;
        logic rac;
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        #1;
        if (rd) chk(tag, bus_rdata, m_read(a));
        else    chk("R11", bus_rdata, 32'h0);
        chk("R10", {31'h0, irq}, {31'h0, |(m_pri() & m_mask)});
        set[0] = {4'h0, g_txdesc, 4'h0, g_txok};
        set[1] = {4'h0, g_txeol, 4'h0, g_txerr};
        set[2] = {10'h0, g_bcn, 1'b0, g_hif, g_txurn};
        set[3] = {2'h0, g_trig, g_urn, g_ovr};
        rac = rd && (a == 4'd5);
        if (rac) for (int i = 0; i < 4; i++) m_shd[i] = m_sec[i];
        for (int i = 0; i < 4; i++) begin
            clr = rac ? 32'hFFFF_FFFF : ((wr && a == 4'(i + 1)) ? wd : 32'h0);
            m_sec[i] = ((m_sec[i] & ~clr) | set[i]) & vmask(i);
        end
        clr = rac ? 32'hFFFF_FFFF : ((wr && a == 4'd0) ? wd : 32'h0);
        m_dir = ((m_dir & ~clr) | g_dir) & ~SUMBITS;
        if (wr && a == 4'd10) m_mask = wd;
        @(posedge clk);
        #1;
        g_txok = '0; g_txdesc = '0; g_txerr = '0; g_txeol = '0; g_txurn = '0;
        g_hif = '0; g_bcn = '0; g_ovr = '0; g_urn = '0; g_trig = '0; g_dir = '0;
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic [3:0] a;
        int op;
        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < 4; i++) begin m_sec[i] = '0; m_shd[i] = '0; end
        m_dir = '0; m_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: all addresses zero after reset
        for (int i = 0; i < 16; i++) step(4'(i), 1'b1, 1'b0, 32'h0, "R1");

        // R2: queue 3 done and CBR queue 9 overrun land in their fields
        g_txok = 12'h008; g_ovr = 10'h200;
        step(4'd0, 1'b0, 1'b0, 32'h0, "R2");
        step(4'd1, 1'b1, 1'b0, 32'h0, "R2");
        step(4'd4, 1'b1, 1'b0, 32'h0, "R2");
        step(4'd0, 1'b1, 1'b0, 32'h0, "R4");

        // R3: transmit-timeout bit latched, summary position ignored
        g_dir = 32'h0000_0240;
        step(4'd0, 1'b0, 1'b0, 32'h0, "R3");
        step(4'd0, 1'b1, 1'b0, 32'h0, "R3");

        // R6: all-ones write to primary keeps pending summaries
        step(4'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R6");
        step(4'd0, 1'b1, 1'b0, 32'h0, "R6");

        // R5: clear the CBR overrun bit, summary 25 falls
        step(4'd4, 1'b0, 1'b1, 32'h0000_0200, "R5");
        step(4'd4, 1'b1, 1'b0, 32'h0, "R5");
        step(4'd0, 1'b1, 1'b0, 32'h0, "R6");

        // R7: event in the same cycle as its clear stays set
        g_txok = 12'h008;
        step(4'd1, 1'b0, 1'b1, 32'h0000_0008, "R7");
        step(4'd1, 1'b1, 1'b0, 32'h0, "R7");

        // R10: mask write and readback, irq follows
        step(4'd10, 1'b0, 1'b1, 32'h0000_0040, "R10");
        step(4'd10, 1'b1, 1'b0, 32'h0, "R10");

        // R8 and R9: alias read with a new event in the same cycle
        g_txerr = 12'h020;
        step(4'd0, 1'b0, 1'b0, 32'h0, "R8");
        g_txok = 12'h002;
        step(4'd5, 1'b1, 1'b0, 32'h0, "R8");
        step(4'd6, 1'b1, 1'b0, 32'h0, "R8");
        step(4'd7, 1'b1, 1'b0, 32'h0, "R8");
        step(4'd1, 1'b1, 1'b0, 32'h0, "R9");
        step(4'd2, 1'b1, 1'b0, 32'h0, "R9");

        // R11: writes to shadow, alias and unmapped addresses do nothing
        step(4'd6, 1'b0, 1'b1, 32'hFFFF_FFFF, "R11");
        step(4'd5, 1'b0, 1'b1, 32'hFFFF_FFFF, "R11");
        step(4'd15, 1'b0, 1'b1, 32'hFFFF_FFFF, "R11");
        step(4'd6, 1'b1, 1'b0, 32'h0, "R11");
        step(4'd1, 1'b1, 1'b0, 32'h0, "R11");
        step(4'd15, 1'b1, 1'b0, 32'h0, "R11");

        // random mix of sparse events and bus traffic
        for (int n = 0; n < 3000; n++) begin
            g_txok   = 12'($urandom & $urandom & $urandom);
            g_txdesc = 12'($urandom & $urandom & $urandom);
            g_txerr  = 12'($urandom & $urandom & $urandom);
            g_txeol  = 12'($urandom & $urandom & $urandom);
            g_txurn  = 12'($urandom & $urandom & $urandom);
            g_hif    = 3'($urandom & $urandom & $urandom);
            g_bcn    = 6'($urandom & $urandom & $urandom);
            g_ovr    = 10'($urandom & $urandom & $urandom);
            g_urn    = 10'($urandom & $urandom & $urandom);
            g_trig   = 10'($urandom & $urandom & $urandom);
            g_dir    = $urandom & $urandom & $urandom;
            a  = 4'($urandom % 16);
            op = int'($urandom % 3);
            if (op == 0)      step(a, 1'b1, 1'b0, 32'h0, tag_of(a));
            else if (op == 1) step(a, 1'b0, 1'b1, $urandom | $urandom, tag_of(a));
            else              step(4'd5, 1'b1, 1'b0, 32'h0, "R9");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule